// File: doc/BRIEF.md
# Serial-Programmed Crossbar Control Registers

This block is the control side of a 12-input, 9-output video crossbar. A host writes to it over a two-wire I2C bus, and the block acts as a write-only target on that bus. Both bus lines are sampled with the system clock. A frame has three bytes: a device address byte, a sub-address byte and one data byte. The block acknowledges each byte it accepts. It commits the data byte to the addressed register once the data acknowledge has completed.

For each crossbar output the block drives three things: an enable, a 2-bit gain code and a one-hot input select. The select is forced to zero whenever its output is disabled. The block also drives a 12-bit vector that chooses clamp or bias for each input. The analog switch fabric uses these signals directly. Several outputs may route the same input at the same time. Sub-addresses that are not defined accept writes without any effect.

Top module: `xbar_ctl_regs`

## Requirements
- R1: After reset, `out_en`, `out_gain`, `out_sel` and `clamp_sel` are all zero: every output is powered down at the lowest gain with nothing routed, and every input is in bias mode.
- R2: The block acknowledges the address byte only when it equals 0x06 with `addr_sel` low, or 0x86 with `addr_sel` high. Any other address byte gets no acknowledge, and the rest of that frame changes nothing.
- R3: After a matched address, the block acknowledges the sub-address byte and the data byte by pulling SDA low (`sda_oe` = 1) during the ninth clock. The write takes effect on the clock after the data acknowledge, before any stop condition. Outputs change at no other time.
- R4: Sub-address k, for k from 1 to 9, holds output k. Data bit 7 drives `out_en[k-1]`, and data bits 6:5 drive `out_gain[2k-1:2k-2]` (00 to 11 stand for 6 to 9 dB). Data bits 4:0 are the input select code.
- R5: Select code c, for c from 1 to 12, sets only bit c-1 of `out_sel[(k-1)*12 +: 12]`. Codes 0 and 13 to 31 set no bit. Each slice is never more than one-hot.
- R6: When an output's enable bit is 0, its `out_sel` slice is zero whatever select code is stored.
- R7: Any number of outputs may select the same input at the same time.
- R8: Sub-address 0x1D data bits 7:0 set `clamp_sel[7:0]`, and sub-address 0x1E data bits 3:0 set `clamp_sel[11:8]` (1 = clamp, 0 = bias). Bits 7:4 written to 0x1E are ignored.
- R9: Writes to any sub-address other than 0x01 to 0x09, 0x1D and 0x1E are acknowledged and change no output.
- R10: A start condition in the middle of a frame discards the partial frame and restarts address reception.
- R11: A byte sent after the data byte in the same frame gets no acknowledge and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Device address select (0: 0x06, 1: 0x86) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| out_en | output | 9 | Enable for each output |
| out_gain | output | 18 | Gain code for each output, two bits per output |
| out_sel | output | 108 | One-hot input select for each output, 12 bits per output |
| clamp_sel | output | 12 | Clamp (1) or bias (0) for each input |

## Verification
A register that holds the wrong value shows up at the ports right away. A bad enable or select bit makes an output route the wrong input or a second input, or lets a disabled output keep a route. The bench sees this as soon as the frame that should have set the value has finished. A decoder that treats out-of-range codes or undefined sub-addresses as valid disturbs a neighbouring output slice or clamp bit, and that is visible at the next comparison. Errors in the receive state machine show up within one byte time, as a missing or extra low level on the data line during the ninth clock.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 5;
  localparam int GAIN_W   = 2;
  localparam int MAX_IN   = 32;

  typedef struct packed {
    logic              en;
    logic [GAIN_W-1:0] gain;
    logic [SEL_W-1:0]  sel;
  } out_ctl_t;

  // Select code to one-hot: codes 1..n_in pick a bit, anything else is empty.
  function automatic logic [MAX_IN-1:0] code_to_onehot(input logic en,
                                                       input logic [SEL_W-1:0] code,
                                                       input int n_in);
    logic [MAX_IN-1:0] v;
    v = '0;
    if (en && code != '0 && int'(code) <= n_in)
      v[int'(code) - 1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/xbar_i2c_wr.sv
module xbar_i2c_wr #(
  parameter logic [7:0] ADDR_LO = 8'h06,
  parameter logic [7:0] ADDR_HI = 8'h86
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_sub,
  output logic [7:0] wr_data,
  output logic       scl_sync,
  output logic       start_det,
  output logic       stop_det
);
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_d, sda_s, sda_d;
  logic       scl_rise, scl_fall, byte_done, addr_match;
  logic [7:0] shreg, dev_addr;
  logic [3:0] bitcnt;
  logic [1:0] idx;
  st_t        state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign scl_s      = scl_p[1];
  assign scl_d      = scl_p[2];
  assign sda_s      = sda_p[1];
  assign sda_d      = sda_p[2];
  assign scl_sync   = scl_s;
  assign scl_rise   = scl_s & ~scl_d;
  assign scl_fall   = ~scl_s & scl_d;
  assign start_det  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det   = scl_s & scl_d & ~sda_d & sda_s;
  assign dev_addr   = addr_sel ? ADDR_HI : ADDR_LO;
  assign addr_match = (shreg == dev_addr);
  assign byte_done  = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      idx     <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_sub  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        idx    <= '0;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (idx == 2'd0 && !addr_match) begin
                state <= ST_IDLE;
              end else begin
                if (idx == 2'd1) wr_sub  <= shreg;
                if (idx == 2'd2) wr_data <= shreg;
                state  <= ST_ACK;
                sda_oe <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (idx == 2'd2) begin
                wr_stb <= 1'b1;
                state  <= ST_IDLE;
              end else begin
                idx   <= idx + 2'd1;
                state <= ST_RX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbar_regfile.sv
module xbar_regfile
  import xbar_pkg::*;
#(
  parameter int         N_IN       = 12,
  parameter int         N_OUT      = 9,
  parameter logic [7:0] CLAMP_BASE = 8'h1D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [7:0]            wr_sub,
  input  logic [7:0]            wr_data,
  output out_ctl_t [N_OUT-1:0]  ctl,
  output logic [N_IN-1:0]       clamp
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctl[k] <= '0;
      else if (wr_stb && wr_sub == 8'(k + 1))
        ctl[k] <= out_ctl_t'(wr_data);
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_clamp
    localparam logic [7:0] BANK = CLAMP_BASE + 8'(i / 8);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        clamp[i] <= 1'b0;
      else if (wr_stb && wr_sub == BANK)
        clamp[i] <= wr_data[i % 8];
    end
  end
endmodule

// File: rtl/xbar_route_decode.sv
module xbar_route_decode
  import xbar_pkg::*;
#(
  parameter int N_IN  = 12,
  parameter int N_OUT = 9
) (
  input  out_ctl_t [N_OUT-1:0]       ctl,
  output logic [N_OUT-1:0]           out_en,
  output logic [N_OUT*GAIN_W-1:0]    out_gain,
  output logic [N_OUT*N_IN-1:0]      out_sel
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_dec
    logic [MAX_IN-1:0] hot;
    assign hot                            = code_to_onehot(ctl[k].en, ctl[k].sel, N_IN);
    assign out_en[k]                      = ctl[k].en;
    assign out_gain[k*GAIN_W +: GAIN_W]   = ctl[k].gain;
    assign out_sel[k*N_IN +: N_IN]        = hot[N_IN-1:0];
    if (N_IN < MAX_IN) begin : g_unused
      logic unused_hi;
      assign unused_hi = |hot[MAX_IN-1:N_IN];
    end
  end
endmodule

// File: rtl/xbar_ctl_regs.sv
module xbar_ctl_regs
  import xbar_pkg::*;
#(
  parameter int         N_IN       = 12,
  parameter int         N_OUT      = 9,
  parameter logic [7:0] ADDR_LO    = 8'h06,
  parameter logic [7:0] ADDR_HI    = 8'h86,
  parameter logic [7:0] CLAMP_BASE = 8'h1D
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    addr_sel,
  output logic                    sda_oe,
  output logic [N_OUT-1:0]        out_en,
  output logic [N_OUT*GAIN_W-1:0] out_gain,
  output logic [N_OUT*N_IN-1:0]   out_sel,
  output logic [N_IN-1:0]         clamp_sel
);
  logic                 wr_stb, scl_sync, start_det, stop_det;
  logic [7:0]           wr_sub, wr_data;
  out_ctl_t [N_OUT-1:0] ctl;

  xbar_i2c_wr #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_sub(wr_sub), .wr_data(wr_data),
    .scl_sync(scl_sync), .start_det(start_det), .stop_det(stop_det)
  );

  xbar_regfile #(.N_IN(N_IN), .N_OUT(N_OUT), .CLAMP_BASE(CLAMP_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sub(wr_sub), .wr_data(wr_data),
    .ctl(ctl), .clamp(clamp_sel)
  );

  xbar_route_decode #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dec (
    .ctl(ctl), .out_en(out_en), .out_gain(out_gain), .out_sel(out_sel)
  );
endmodule

// File: rtl/xbar_ctl_chk.sv
module xbar_ctl_chk #(
  parameter int N_IN  = 12,
  parameter int N_OUT = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_sync,
  input logic                  sda_oe,
  input logic                  wr_stb,
  input logic                  start_det,
  input logic                  stop_det,
  input logic [N_OUT-1:0]      out_en,
  input logic [N_OUT*2-1:0]    out_gain,
  input logic [N_OUT*N_IN-1:0] out_sel,
  input logic [N_IN-1:0]       clamp_sel
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_sel[k*N_IN +: N_IN]));
    // R6
    off_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[k] |-> out_sel[k*N_IN +: N_IN] == '0);
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> ($stable(out_en) && $stable(out_gain) && $stable(out_sel)));
  // R8
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> $stable(clamp_sel));
  // R2
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R10
  no_ack_on_frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);
endmodule

bind xbar_ctl_regs xbar_ctl_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .sda_oe(sda_oe), .wr_stb(wr_stb),
  .start_det(start_det), .stop_det(stop_det), .out_en(out_en), .out_gain(out_gain),
  .out_sel(out_sel), .clamp_sel(clamp_sel)
);

// File: tb/tb_xbar_ctl_regs.sv
module tb_xbar_ctl_regs;
  localparam int NI = 12;
  localparam int NO = 9;
  localparam int NV = 14;
  // Each entry: {sub-address, data}
  localparam logic [15:0] VEC [0:NV-1] = '{
    {8'h01, 8'hA3},  // R4 R5: out1 on, gain 01, input 3
    {8'h02, 8'hE3},  // R7: out2 also input 3, gain 11
    {8'h09, 8'h8C},  // R5: top code 12 on last output
    {8'h03, 8'h8D},  // R5: code 13 routes nothing
    {8'h04, 8'h91},  // R5: code 17 (bit 4 set) routes nothing
    {8'h05, 8'h41},  // R6: disabled with code 1 stored
    {8'h05, 8'hC1},  // R6: enabled, code 1 now routes
    {8'h1D, 8'hA5},  // R8: low clamp bank
    {8'h1E, 8'hF6},  // R8: high bank, upper nibble ignored
    {8'h00, 8'hFF},  // R9
    {8'h0A, 8'hFF},  // R9
    {8'h1C, 8'hFF},  // R9
    {8'h1F, 8'hFF},  // R9
    {8'h01, 8'h00}   // R4: out1 back to off
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, sda_bus;
  logic [NO-1:0]    out_en;
  logic [NO*2-1:0]  out_gain;
  logic [NO*NI-1:0] out_sel;
  logic [NI-1:0]    clamp_sel;
  logic [7:0]       m_ctl [0:NO-1];
  logic [NI-1:0]    m_clamp;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  xbar_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .out_en(out_en), .out_gain(out_gain), .out_sel(out_sel),
    .clamp_sel(clamp_sel)
  );

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = ~sda_bus;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                       output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte(a, k); acks[2] = k;
    send_byte(s, k); acks[1] = k;
    send_byte(d, k); acks[0] = k;
    bus_stop();
    q();
  endtask

  // Expected-state model written from the requirements.
  task automatic model_write(input logic [7:0] s, input logic [7:0] d);
    if (s >= 8'd1 && s <= 8'd9) m_ctl[s - 8'd1] = d;
    else if (s == 8'h1D) m_clamp[7:0] = d;
    else if (s == 8'h1E) m_clamp[11:8] = d[3:0];
  endtask

  task automatic check_outs(input string tag);
    logic [NO-1:0]    e_en;
    logic [NO*2-1:0]  e_gain;
    logic [NO*NI-1:0] e_sel;
    for (int k = 0; k < NO; k++) begin
      e_en[k] = m_ctl[k][7];
      e_gain[2*k +: 2] = m_ctl[k][6:5];
      for (int i = 0; i < NI; i++)
        e_sel[k*NI + i] = m_ctl[k][7] && (int'(m_ctl[k][4:0]) == i + 1);
    end
    n_chk++;
    if (out_en !== e_en || out_gain !== e_gain || out_sel !== e_sel || clamp_sel !== m_clamp) begin
      n_bad++;
      $display("FAIL %s en=%h/%h gain=%h/%h sel=%h/%h clamp=%h/%h (actual/expected)", tag,
               out_en, e_en, out_gain, e_gain, out_sel, e_sel, clamp_sel, m_clamp);
    end
  endtask

  task automatic check_ack(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s acks=%b expected=%b", tag, got, exp);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [2:0] acks;
    logic k;
    for (int i = 0; i < NO; i++) m_ctl[i] = 8'h00;
    m_clamp = '0;
    repeat (4) @(negedge clk);
    check_outs("R1 reset state");
    rst_n = 1'b1;
    q();
    check_outs("R1 after reset release");

    for (int v = 0; v < NV; v++) begin
      frame(8'h06, VEC[v][15:8], VEC[v][7:0], acks);
      model_write(VEC[v][15:8], VEC[v][7:0]);
      check_ack("R3 R9 table acks", acks, 3'b111);
      check_outs("R4 R5 R6 R7 R8 R9 table outputs");
    end

    // R2: wrong forms of the address are not acknowledged
    frame(8'h86, 8'h02, 8'h81, acks);
    check_ack("R2 0x86 with select low", acks, 3'b000);
    frame(8'h07, 8'h02, 8'h81, acks);
    check_ack("R2 read-bit address", acks, 3'b000);
    check_outs("R2 no change on mismatch");
    addr_sel = 1'b1; q();
    frame(8'h06, 8'h02, 8'h81, acks);
    check_ack("R2 0x06 with select high", acks, 3'b000);
    frame(8'h86, 8'h06, 8'hA2, acks);
    model_write(8'h06, 8'hA2);
    check_ack("R2 0x86 with select high", acks, 3'b111);
    check_outs("R2 high address write");
    addr_sel = 1'b0; q();

    // R10: restart after a partial sub-address
    bus_start();
    send_byte(8'h06, k);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    frame(8'h06, 8'h07, 8'h84, acks);
    model_write(8'h07, 8'h84);
    check_ack("R10 restart frame acks", acks, 3'b111);
    check_outs("R10 restart frame outputs");

    // R3 R11: commit before stop, extra byte not acknowledged
    bus_start();
    send_byte(8'h06, k);
    send_byte(8'h08, k);
    send_byte(8'h85, k);
    model_write(8'h08, 8'h85);
    q();
    check_outs("R3 commit after data ack");
    send_byte(8'h00, k);
    check_ack("R11 extra byte", {2'b00, k}, 3'b000);
    bus_stop(); q();
    check_outs("R11 extra byte no change");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule